// File: doc/BRIEF.md
# Privileged Special Register Access Gate

This block sits between a processor's execute stage and its special-register file. Each cycle it can take one move-from request (`rd_en`), one move-to request (`wr_en`), or both, at a 16-bit address. The top 5 bits of the address select a register group and the low 11 bits select an index within that group. Requests are honoured only when the core is in supervisor mode or software has set the user special-register access bit.

Reads complete combinationally in the same cycle. The gate selects one of the registers the core presents, or an entry of the 512-entry shadow general-register window, which is stored inside the gate. Every other result appears on registered outputs one clock after the request:
- **Register write:** a target code, the write value, and a valid pulse.
- **Next-PC write:** a fetch redirect that also flushes pending delay-slot state.
- **Warning:** a one-cycle pulse that carries the address which caused it.

A write to the status register always leaves its fixed-one bit set. A write to the tick-timer mode register changes nothing.

The gate has no stateful sequencing of its own. Its only states are two:
- **Reset:** all registered outputs are low.
- **Run:** each request is classified by one unique-case decode into a read source and a write kind. The write kinds are drop, plain register, shadow window, redirect and timer-mode.

Leaving reset (the reset-to-run transition) is the only transition.

Top module: `spr_gate`

## Requirements
- R1: An access is performed only when `sup_mode` or `user_spr_en` is 1. A refused read returns 0. A refused write changes no register, shadow entry or redirect. Either refused request raises a warning.
- R2: An address whose value is 0x5800 or above is invalid. A read of it returns 0, a write to it is dropped, and both raise a warning. An address below 0x5800 that matches no register is handled the same way.
- R3: Reads return the presented value in the same cycle for these addresses: version 0x0000, unit-present 0x0001, CPU-config 0x0002, status 0x0011, previous-PC 0x0012, FPU control 0x0014, exception-PC 0x0020, MAC low 0x2801 and MAC high 0x2802. Reading next-PC 0x0010, saved-status 0x0040 or timer-mode 0x5000 returns 0 and warns. `rd_data` is 0 whenever `rd_en` is 0.
- R4: A permitted write produces `wr_valid`=1 one cycle later, with `wr_target` and `wr_data` set, for these addresses and target codes: FPU control 0x0014 (code 1), exception-PC 0x0020 (code 2), saved-status 0x0040 (code 3), MAC low 0x2801 (code 4) and MAC high 0x2802 (code 5). A write to a read-only register such as 0x0000 is dropped with a warning.
- R5: A write to the status register 0x0011 yields target code 6, with data equal to the written value with bit 15 forced to 1.
- R6: A permitted write to next-PC 0x0010 pulses `redir_flush` one cycle later, with `redir_pc` equal to the written value. It produces no `wr_valid`.
- R7: A write to timer-mode 0x5000 produces no register write and no redirect. A zero value raises no warning; a nonzero value raises a warning.
- R8: A write to shadow address 0x0400+i (0 ≤ i < 512) stores the value at the clock edge. A later read of that address returns the stored value. A read and a write to the same entry in one cycle return the old value.
- R9: `warn_pulse` is high for exactly the cycle after each offending request, with `warn_addr` equal to that request's address. Outside that cycle both are 0. `wr_data` and `redir_pc` are likewise 0 when their pulses are low.
- R10: During reset, `wr_valid`, `wr_target`, `wr_data`, `redir_flush`, `redir_pc`, `warn_pulse` and `warn_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Move-from request |
| wr_en | input | 1 | Move-to request |
| req_addr | input | 16 | Register address: group [15:11], index [10:0] |
| req_wdata | input | 32 | Write value |
| sup_mode | input | 1 | Core is in supervisor mode |
| user_spr_en | input | 1 | User-mode register access permitted |
| ver_val | input | 32 | Current version register value |
| unit_val | input | 32 | Current unit-present register value |
| cfg_val | input | 32 | Current CPU-config register value |
| sr_val | input | 32 | Current status register value |
| ppc_val | input | 32 | Current previous-PC value |
| fpcsr_val | input | 32 | Current FPU control/status value |
| epc_val | input | 32 | Current exception-PC value |
| maclo_val | input | 32 | Current MAC accumulator low half |
| machi_val | input | 32 | Current MAC accumulator high half |
| rd_data | output | 32 | Same-cycle read result |
| wr_valid | output | 1 | Register-file write pulse |
| wr_target | output | 3 | Write target code (see R4, R5) |
| wr_data | output | 32 | Value to write |
| redir_flush | output | 1 | Fetch redirect and delay-slot flush pulse |
| redir_pc | output | 32 | Redirect target |
| warn_pulse | output | 1 | Warning pulse |
| warn_addr | output | 16 | Address that caused the warning |

## Verification
A decode slip shows up in the same cycle as a wrong or nonzero `rd_data`. It shows up one cycle later as a write pulse, target code or warning that the request should not have produced. Corruption in the shadow window stays hidden until that entry is read back, so the bench writes both ends of the window and re-reads them after refused and simultaneous accesses. A stuck pulse register is exposed on the next idle cycle, where every registered output must return to 0.

// File: rtl/spr_gate_pkg.sv
`timescale 1ns/1ps
package spr_gate_pkg;

    localparam int AW = 16;
    localparam int DW = 32;

    localparam logic [AW-1:0] ADDR_VER   = 16'h0000;
    localparam logic [AW-1:0] ADDR_UNIT  = 16'h0001;
    localparam logic [AW-1:0] ADDR_CFG   = 16'h0002;
    localparam logic [AW-1:0] ADDR_NPC   = 16'h0010;
    localparam logic [AW-1:0] ADDR_SR    = 16'h0011;
    localparam logic [AW-1:0] ADDR_PPC   = 16'h0012;
    localparam logic [AW-1:0] ADDR_FPCSR = 16'h0014;
    localparam logic [AW-1:0] ADDR_EPC   = 16'h0020;
    localparam logic [AW-1:0] ADDR_ESR   = 16'h0040;
    localparam logic [AW-1:0] GPR_BASE   = 16'h0400;
    localparam logic [AW-1:0] ADDR_MACLO = 16'h2801;
    localparam logic [AW-1:0] ADDR_MACHI = 16'h2802;
    localparam logic [AW-1:0] ADDR_TICK  = 16'h5000;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_FPCSR = 3'd1,
        TGT_EPC   = 3'd2,
        TGT_ESR   = 3'd3,
        TGT_MACLO = 3'd4,
        TGT_MACHI = 3'd5,
        TGT_SR    = 3'd6
    } wtgt_e;

    typedef enum logic [3:0] {
        RS_ZERO, RS_VER, RS_UNIT, RS_CFG, RS_SR, RS_PPC,
        RS_FPCSR, RS_EPC, RS_MACLO, RS_MACHI, RS_GPR
    } rsrc_e;

    typedef enum logic [2:0] {
        WK_DROP, WK_REG, WK_GPR, WK_NPC, WK_TICK
    } wkind_e;

endpackage

// File: rtl/spr_addr_decode.sv
`timescale 1ns/1ps
module spr_addr_decode
    import spr_gate_pkg::*;
#(
    parameter int GPR_DEPTH = 512
) (
    input  logic [AW-1:0] addr,
    output rsrc_e         rsel,
    output wkind_e        wkind,
    output wtgt_e         wtgt
);
    localparam logic [AW:0] WIN_LO = {1'b0, GPR_BASE};
    localparam logic [AW:0] WIN_HI = WIN_LO + (AW+1)'(GPR_DEPTH);

    logic in_window;
    assign in_window = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);

    always_comb begin
        rsel  = RS_ZERO;
        wkind = WK_DROP;
        wtgt  = TGT_NONE;
        unique case (addr)
            ADDR_VER:   rsel = RS_VER;
            ADDR_UNIT:  rsel = RS_UNIT;
            ADDR_CFG:   rsel = RS_CFG;
            ADDR_PPC:   rsel = RS_PPC;
            ADDR_NPC:   wkind = WK_NPC;
            ADDR_TICK:  wkind = WK_TICK;
            ADDR_SR: begin
                rsel = RS_SR;    wkind = WK_REG; wtgt = TGT_SR;
            end
            ADDR_FPCSR: begin
                rsel = RS_FPCSR; wkind = WK_REG; wtgt = TGT_FPCSR;
            end
            ADDR_EPC: begin
                rsel = RS_EPC;   wkind = WK_REG; wtgt = TGT_EPC;
            end
            ADDR_ESR: begin
                wkind = WK_REG;  wtgt = TGT_ESR;
            end
            ADDR_MACLO: begin
                rsel = RS_MACLO; wkind = WK_REG; wtgt = TGT_MACLO;
            end
            ADDR_MACHI: begin
                rsel = RS_MACHI; wkind = WK_REG; wtgt = TGT_MACHI;
            end
            default: begin
                if (in_window) begin
                    rsel  = RS_GPR;
                    wkind = WK_GPR;
                end
            end
        endcase
    end
endmodule

// File: rtl/spr_shadow_bank.sv
`timescale 1ns/1ps
module spr_shadow_bank #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spr_gate.sv
`timescale 1ns/1ps
module spr_gate
    import spr_gate_pkg::*;
#(
    parameter int GPR_DEPTH = 512,
    parameter int FO_BIT    = 15,
    parameter int NUM_REGS  = 'h5800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [15:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic        sup_mode,
    input  logic        user_spr_en,
    input  logic [31:0] ver_val,
    input  logic [31:0] unit_val,
    input  logic [31:0] cfg_val,
    input  logic [31:0] sr_val,
    input  logic [31:0] ppc_val,
    input  logic [31:0] fpcsr_val,
    input  logic [31:0] epc_val,
    input  logic [31:0] maclo_val,
    input  logic [31:0] machi_val,
    output logic [31:0] rd_data,
    output logic        wr_valid,
    output logic [2:0]  wr_target,
    output logic [31:0] wr_data,
    output logic        redir_flush,
    output logic [31:0] redir_pc,
    output logic        warn_pulse,
    output logic [15:0] warn_addr
);
    localparam int          IW      = $clog2(GPR_DEPTH);
    localparam logic [AW:0] LIMIT   = (AW+1)'(NUM_REGS);
    localparam logic [DW-1:0] FO_MASK = DW'(1) << FO_BIT;

    rsrc_e  dec_rsel;
    wkind_e dec_wkind;
    wtgt_e  dec_tgt;

    spr_addr_decode #(.GPR_DEPTH(GPR_DEPTH)) u_dec (
        .addr  (req_addr),
        .rsel  (dec_rsel),
        .wkind (dec_wkind),
        .wtgt  (dec_tgt)
    );

    logic          allowed, in_range, rd_ok, wr_pass;
    logic          gpr_we, reg_we, npc_we, tick_bad, warn_next;
    logic [IW-1:0] gidx;
    logic [DW-1:0] gpr_rdata, sel_val;

    assign allowed  = sup_mode | user_spr_en;
    assign in_range = {1'b0, req_addr} < LIMIT;
    assign gidx     = IW'(req_addr - GPR_BASE);

    spr_shadow_bank #(.DEPTH(GPR_DEPTH), .DW(DW)) u_bank (
        .clk   (clk),
        .we    (gpr_we),
        .waddr (gidx),
        .wdata (req_wdata),
        .raddr (gidx),
        .rdata (gpr_rdata)
    );

    always_comb begin
        sel_val = '0;
        unique case (dec_rsel)
            RS_ZERO:  sel_val = '0;
            RS_VER:   sel_val = ver_val;
            RS_UNIT:  sel_val = unit_val;
            RS_CFG:   sel_val = cfg_val;
            RS_SR:    sel_val = sr_val;
            RS_PPC:   sel_val = ppc_val;
            RS_FPCSR: sel_val = fpcsr_val;
            RS_EPC:   sel_val = epc_val;
            RS_MACLO: sel_val = maclo_val;
            RS_MACHI: sel_val = machi_val;
            RS_GPR:   sel_val = gpr_rdata;
            default:  sel_val = '0;
        endcase
    end

    assign rd_ok   = rd_en & allowed & in_range & (dec_rsel != RS_ZERO);
    assign rd_data = rd_ok ? sel_val : '0;

    assign wr_pass   = wr_en & allowed & in_range;
    assign gpr_we    = wr_pass & (dec_wkind == WK_GPR);
    assign reg_we    = wr_pass & (dec_wkind == WK_REG);
    assign npc_we    = wr_pass & (dec_wkind == WK_NPC);
    assign tick_bad  = wr_pass & (dec_wkind == WK_TICK) & (req_wdata != '0);
    assign warn_next = (rd_en & ~rd_ok)
                     | (wr_en & (~wr_pass | (dec_wkind == WK_DROP)))
                     | tick_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid    <= 1'b0;
            wr_target   <= TGT_NONE;
            wr_data     <= '0;
            redir_flush <= 1'b0;
            redir_pc    <= '0;
            warn_pulse  <= 1'b0;
            warn_addr   <= '0;
        end else begin
            wr_valid    <= reg_we;
            wr_target   <= reg_we ? dec_tgt : TGT_NONE;
            wr_data     <= !reg_we ? '0 :
                           (dec_tgt == TGT_SR) ? (req_wdata | FO_MASK) : req_wdata;
            redir_flush <= npc_we;
            redir_pc    <= npc_we ? req_wdata : '0;
            warn_pulse  <= warn_next;
            warn_addr   <= warn_next ? req_addr : '0;
        end
    end

    // R1
    refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sup_mode && !user_spr_en) |-> (rd_data == '0));

    // R1
    refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || redir_flush) |-> $past(sup_mode || user_spr_en));

    // R2
    invalid_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ({1'b0, req_addr} >= LIMIT)) |-> (rd_data == '0));

    // R5
    sr_fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_target == TGT_SR) |-> wr_data[FO_BIT]);

    // R6
    redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_flush |-> ($past(wr_en && req_addr == ADDR_NPC) && !wr_valid));

    // R7
    tick_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && req_addr == ADDR_TICK && req_wdata == '0)
        |=> (!warn_pulse && !wr_valid && !redir_flush));

    // R9
    warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> $past(rd_en || wr_en));
endmodule

// File: tb/tb_spr_gate.sv
`timescale 1ns/1ps
module tb_spr_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic        sup_mode = 1'b0, user_spr_en = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;

    localparam logic [31:0] V_VER = 32'hA000_0001, V_UNIT = 32'h0000_00FF,
                            V_CFG = 32'h0000_0020, V_SR = 32'h0000_8001,
                            V_PPC = 32'h0000_1000, V_FPCSR = 32'h0000_0004,
                            V_EPC = 32'h0000_2000, V_MACLO = 32'h1111_2222,
                            V_MACHI = 32'h3333_4444;

    logic [31:0] rd_data, wr_data, redir_pc;
    logic        wr_valid, redir_flush, warn_pulse;
    logic [2:0]  wr_target;
    logic [15:0] warn_addr;

    spr_gate dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .sup_mode(sup_mode), .user_spr_en(user_spr_en),
        .ver_val(V_VER), .unit_val(V_UNIT), .cfg_val(V_CFG), .sr_val(V_SR),
        .ppc_val(V_PPC), .fpcsr_val(V_FPCSR), .epc_val(V_EPC),
        .maclo_val(V_MACLO), .machi_val(V_MACHI),
        .rd_data(rd_data), .wr_valid(wr_valid), .wr_target(wr_target),
        .wr_data(wr_data), .redir_flush(redir_flush), .redir_pc(redir_pc),
        .warn_pulse(warn_pulse), .warn_addr(warn_addr)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic        wv;
        logic [2:0]  wt;
        logic [31:0] wd;
        logic        rf;
        logic [31:0] rpc;
        logic        wn;
        logic [15:0] wa;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    task automatic req(input logic r, input logic w, input logic [15:0] a,
                       input logic [31:0] d, input logic sm, input logic ue,
                       input logic [31:0] erd, input logic ewv, input logic [2:0] ewt,
                       input logic [31:0] ewd, input logic erf, input logic ewn,
                       input string tag);
        exp_t e;
        @(negedge clk);
        rd_en = r; wr_en = w; req_addr = a; req_wdata = d;
        sup_mode = sm; user_spr_en = ue;
        #1;
        n_run++;
        if (rd_data !== erd) begin
            n_fail++;
            $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, erd);
        end
        e.wv = ewv; e.wt = ewt; e.wd = ewd;
        e.rf = erf; e.rpc = erf ? d : 32'h0;
        e.wn = ewn; e.wa = ewn ? a : 16'h0;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic rd(input logic [15:0] a, input logic sm, input logic ue,
                      input logic [31:0] erd, input logic ewn, input string tag);
        req(1'b1, 1'b0, a, 32'h0, sm, ue, erd, 1'b0, 3'd0, 32'h0, 1'b0, ewn, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic sm,
                      input logic ue, input logic ewv, input logic [2:0] ewt,
                      input logic [31:0] ewd, input logic erf, input logic ewn,
                      input string tag);
        req(1'b0, 1'b1, a, d, sm, ue, 32'h0, ewv, ewt, ewd, erf, ewn, tag);
    endtask

    task automatic idle(input string tag);
        req(1'b0, 1'b0, 16'h0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 32'h0,
            1'b0, 1'b0, tag);
    endtask

    // monitor: one expected item per request cycle, compared after the edge
    always @(posedge clk) begin
        exp_t  e;
        string t;
        #1;
        if (expq.size() != 0) begin
            e = expq.pop_front();
            t = tagq.pop_front();
            n_run++;
            if ({wr_valid, wr_target, wr_data, redir_flush, redir_pc, warn_pulse, warn_addr}
                !== {e.wv, e.wt, e.wd, e.rf, e.rpc, e.wn, e.wa}) begin
                n_fail++;
                $display("FAIL %s outputs actual %h expected %h", t,
                    {wr_valid, wr_target, wr_data, redir_flush, redir_pc, warn_pulse, warn_addr},
                    {e.wv, e.wt, e.wd, e.rf, e.rpc, e.wn, e.wa});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;   // R10 reset state
        if ({wr_valid, wr_target, wr_data, redir_flush, redir_pc, warn_pulse, warn_addr} !== '0) begin
            n_fail++;
            $display("FAIL R10 reset outputs actual %h expected 0",
                {wr_valid, wr_target, wr_data, redir_flush, redir_pc, warn_pulse, warn_addr});
        end
        rst_n = 1'b1;

        // R3 readable set
        rd(16'h0000, 1, 0, V_VER,   0, "R3 version");
        rd(16'h0001, 1, 0, V_UNIT,  0, "R3 unit");
        rd(16'h0002, 1, 0, V_CFG,   0, "R3 cfg");
        rd(16'h0011, 1, 0, V_SR,    0, "R3 status");
        rd(16'h0012, 1, 0, V_PPC,   0, "R3 ppc");
        rd(16'h0014, 1, 0, V_FPCSR, 0, "R3 fpcsr");
        rd(16'h0020, 1, 0, V_EPC,   0, "R3 epc");
        rd(16'h2801, 1, 0, V_MACLO, 0, "R3 maclo");
        rd(16'h2802, 1, 0, V_MACHI, 0, "R3 machi");
        rd(16'h0040, 1, 0, 32'h0, 1, "R3 esr unreadable");
        rd(16'h0010, 1, 0, 32'h0, 1, "R3 npc unreadable");
        rd(16'h5000, 1, 0, 32'h0, 1, "R3 tick unreadable");
        idle("R9 warn cleared");

        // R4 writable set
        wr(16'h0014, 32'h0000_DEAD, 1, 0, 1, 3'd1, 32'h0000_DEAD, 0, 0, "R4 fpcsr");
        wr(16'h0020, 32'h0000_4000, 1, 0, 1, 3'd2, 32'h0000_4000, 0, 0, "R4 epc");
        wr(16'h0040, 32'h0000_0123, 1, 0, 1, 3'd3, 32'h0000_0123, 0, 0, "R4 esr");
        wr(16'h2801, 32'hCAFE_0001, 1, 0, 1, 3'd4, 32'hCAFE_0001, 0, 0, "R4 maclo");
        wr(16'h2802, 32'hCAFE_0002, 1, 0, 1, 3'd5, 32'hCAFE_0002, 0, 0, "R4 machi");
        wr(16'h0000, 32'h1234_5678, 1, 0, 0, 3'd0, 32'h0, 0, 1, "R4 readonly dropped");
        wr(16'h0003, 32'h1234_5678, 1, 0, 0, 3'd0, 32'h0, 0, 1, "R2 unlisted dropped");

        // R5 status fixed-one bit
        wr(16'h0011, 32'h0000_0001, 1, 0, 1, 3'd6, 32'h0000_8001, 0, 0, "R5 sr low");
        wr(16'h0011, 32'h8000_0000, 0, 1, 1, 3'd6, 32'h8000_8000, 0, 0, "R5 sr user");

        // R6 redirect
        wr(16'h0010, 32'h0000_3000, 1, 0, 0, 3'd0, 32'h0, 1, 0, "R6 npc redirect");
        idle("R6 redirect pulse ends");

        // R7 timer mode
        wr(16'h5000, 32'h0, 1, 0, 0, 3'd0, 32'h0, 0, 0, "R7 tick zero");
        wr(16'h5000, 32'h5, 1, 0, 0, 3'd0, 32'h0, 0, 1, "R7 tick nonzero");

        // R8 shadow window
        wr(16'h0400, 32'hAAAA_0000, 1, 0, 0, 3'd0, 32'h0, 0, 0, "R8 write first");
        wr(16'h05FF, 32'hBBBB_01FF, 1, 0, 0, 3'd0, 32'h0, 0, 0, "R8 write last");
        rd(16'h0400, 1, 0, 32'hAAAA_0000, 0, "R8 read first");
        rd(16'h05FF, 0, 1, 32'hBBBB_01FF, 0, "R8 read last user");
        wr(16'h0402, 32'h0000_0111, 1, 0, 0, 3'd0, 32'h0, 0, 0, "R8 write mid");
        req(1, 1, 16'h0402, 32'h0000_0222, 1, 0, 32'h0000_0111, 0, 3'd0, 32'h0, 0, 0,
            "R8 same cycle old value");
        rd(16'h0402, 1, 0, 32'h0000_0222, 0, "R8 new value");

        // R1 privilege
        rd(16'h0400, 0, 0, 32'h0, 1, "R1 refused read");
        wr(16'h0400, 32'hDEAD_BEEF, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R1 refused gpr write");
        rd(16'h0400, 1, 0, 32'hAAAA_0000, 0, "R1 gpr unchanged");
        wr(16'h0014, 32'h0000_0001, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R1 refused reg write");
        wr(16'h0010, 32'h0000_5000, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R1 refused redirect");

        // R2 invalid address
        rd(16'h5800, 1, 0, 32'h0, 1, "R2 read limit");
        wr(16'h5800, 32'h1, 1, 0, 0, 3'd0, 32'h0, 0, 1, "R2 write limit");
        rd(16'hFFFF, 1, 0, 32'h0, 1, "R2 read top");
        wr(16'h0600, 32'h77, 1, 0, 0, 3'd0, 32'h0, 0, 1, "R2 beyond window write");
        rd(16'h0600, 1, 0, 32'h0, 1, "R2 beyond window read");
        rd(16'h05FF, 1, 0, 32'hBBBB_01FF, 0, "R8 last entry intact");
        idle("R9 idle after warn");
        idle("R9 idle");

        wait (expq.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule